// File: doc/BRIEF.md
# Indirect Effective Address Generator

This unit turns the address fields of a memory-reference instruction into a final 15-bit word address. From an 8-bit displacement, a 2-bit addressing mode, an indirect flag, the program counter and two index accumulators, it forms a first address. That address is either a page-zero location, a PC-relative location or an offset from one of the two index accumulators. When the indirect flag is clear, that address is the result, one cycle after the request.

When the indirect flag is set, the unit walks a pointer chain through a synchronous single-port memory. It reads a word, and if the word's most significant bit is set, the low 15 bits name the next word to read. The walk stops at the first word whose most significant bit is clear, and that word's low 15 bits are the result. Pointers read from two small reserved windows in low memory are stepped up or down by one. Each stepped pointer is written back in the cycle in which it is evaluated and is then used as the fetched value. An optional level limit stops a chain that never terminates and flags it.

The requester pulses `start` while `busy_o` is low, then waits for the one-cycle `done_o` pulse. `ea_o` and `err_o` are valid in that cycle.

Top module: `ea_chain_gen`

## Requirements
- R1: Mode 00 (page zero): the address is the displacement zero-extended to 15 bits (0 to 255).
- R2: Mode 01 (PC-relative): the address is the PC plus the displacement sign-extended from bit 7, wrapped modulo 2^15.
- R3: Modes 10 and 11: the address is bits 14:0 of index accumulator A (mode 10) or B (mode 11) plus the sign-extended displacement, wrapped modulo 2^15. Bit 15 of the accumulator has no effect.
- R4: With `ind_i` low, `done_o` pulses for one cycle right after the edge that accepts `start`, with the address on `ea_o`, and no memory access is made.
- R5: With `ind_i` high, each level issues one read (`mem_rdata_i` valid the cycle after `mem_rd_o`). A fetched word with bit 15 set continues the chain at bits 14:0. A word with bit 15 clear ends it with `ea_o` = bits 14:0. For N words read, `done_o` rises 2N edges after the accepting edge.
- R6: A word read from addresses 16 to 23 (octal 20 to 27) is incremented modulo 2^16. The new value is written to the same address in the evaluation cycle and is used as the fetched word.
- R7: A word read from addresses 24 to 31 (octal 30 to 37) is decremented modulo 2^16, written back in the same way and used as the fetched word.
- R8: No write occurs outside addresses 16 to 31, and `mem_rd_o` and `mem_wr_o` are never high in the same cycle.
- R9: If MAX_LEVELS words have been read and the last one still has bit 15 set, `done_o` pulses with `err_o` high. A chain of exactly MAX_LEVELS words that ends normally does not raise `err_o`.
- R10: `start` is ignored while `busy_o` is high.
- R11: After reset, `done_o`, `err_o`, `busy_o`, `mem_rd_o` and `mem_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| ind_i | input | 1 | Indirect flag |
| mode_i | input | 2 | Addressing mode |
| disp_i | input | 8 | Displacement |
| pc_i | input | 15 | Program counter |
| acc_a_i | input | 16 | Index accumulator A (mode 10) |
| acc_b_i | input | 16 | Index accumulator B (mode 11) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 15 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the read strobe |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ea_o | output | 15 | Effective address |
| err_o | output | 1 | Level limit reached, valid with done_o |

## Verification
In the evaluation cycle of a level, the write-back of a stepped pointer coincides with the decision to end the chain or to follow it. The bench provokes this with pointers in both windows. Some stepped values end the walk. Others gain or lose bit 15 through the step (0x7FFF up, 0x0000 down), and some lead into further window words. The outcome is judged by comparing, against a reference walk over a shadow memory, the final address, the exact cycle count and the full memory contents after each request.

// File: rtl/ea_chain_pkg.sv
package ea_chain_pkg;
    localparam int AW = 15;
    localparam int DW = 16;
    localparam int DISP_W = 8;

    // reserved pointer windows: [WIN_BASE, WIN_BASE+WIN_LEN) increment,
    // next WIN_LEN words decrement
    localparam logic [AW-1:0] WIN_BASE = 15'd16;
    localparam int WIN_LEN = 8;

    typedef enum logic [1:0] {
        AM_PAGE0 = 2'b00,
        AM_PCREL = 2'b01,
        AM_IDXA  = 2'b10,
        AM_IDXB  = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL
    } ea_state_e;

    typedef struct packed {
        ea_state_e      st;
        logic [AW-1:0]  ptr;
        logic [AW-1:0]  ea;
        logic           done;
        logic           err;
    } ea_regs_t;
endpackage

// File: rtl/ea_base_calc.sv
module ea_base_calc
    import ea_chain_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     pc,
    input  logic [DW-1:0]     acc_a,
    input  logic [DW-1:0]     acc_b,
    output logic [AW-1:0]     base
);
    localparam int EXT_W = AW - DISP_W;

    logic [AW-1:0] disp_sx;
    logic [AW-1:0] disp_zx;

    assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign disp_zx = {{EXT_W{1'b0}}, disp};

    always_comb begin
        unique case (amode_e'(mode))
            AM_PAGE0: base = disp_zx;
            AM_PCREL: base = pc + disp_sx;
            AM_IDXA:  base = acc_a[AW-1:0] + disp_sx;
            default:  base = acc_b[AW-1:0] + disp_sx;
        endcase
    end
endmodule

// File: rtl/ea_autoidx.sv
module ea_autoidx
    import ea_chain_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] word_in,
    output logic          hit,
    output logic [DW-1:0] word_out
);
    logic in_inc;
    logic in_dec;

    assign in_inc = (addr >= WIN_BASE) && (addr < WIN_BASE + AW'(WIN_LEN));
    assign in_dec = (addr >= WIN_BASE + AW'(WIN_LEN)) &&
                    (addr < WIN_BASE + AW'(2 * WIN_LEN));
    assign hit = in_inc || in_dec;

    always_comb begin
        if (in_inc)      word_out = word_in + DW'(1);
        else if (in_dec) word_out = word_in - DW'(1);
        else             word_out = word_in;
    end
endmodule

// File: rtl/ea_level_limit.sv
module ea_level_limit #(
    parameter int MAX_LEVELS = 8,
    parameter bit LIMIT_EN   = 1'b1,
    localparam int LW        = $clog2(MAX_LEVELS + 1)
) (
    input  logic [LW-1:0] lvl,
    output logic          at_limit
);
    generate
        if (LIMIT_EN) begin : g_lim
            assign at_limit = (lvl >= LW'(MAX_LEVELS - 1));
        end else begin : g_nolim
            logic unused_lvl;
            assign unused_lvl = ^lvl;
            assign at_limit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ea_chain_gen.sv
module ea_chain_gen
    import ea_chain_pkg::*;
#(
    parameter int MAX_LEVELS = 8,
    parameter bit LIMIT_EN   = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ind_i,
    input  logic [1:0]    mode_i,
    input  logic [7:0]    disp_i,
    input  logic [14:0]   pc_i,
    input  logic [15:0]   acc_a_i,
    input  logic [15:0]   acc_b_i,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [14:0]   mem_addr_o,
    output logic [15:0]   mem_wdata_o,
    input  logic [15:0]   mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [14:0]   ea_o,
    output logic          err_o
);
    localparam int LW = $clog2(MAX_LEVELS + 1);

    ea_regs_t      r_d, r_q;
    logic [LW-1:0] lvl_d, lvl_q;

    logic [AW-1:0] base_addr;
    logic          ptr_hit;
    logic [DW-1:0] word_mod;
    logic          lim_hit;

    ea_base_calc u_base (
        .mode  (mode_i),
        .disp  (disp_i),
        .pc    (pc_i),
        .acc_a (acc_a_i),
        .acc_b (acc_b_i),
        .base  (base_addr)
    );

    ea_autoidx u_aidx (
        .addr     (r_q.ptr),
        .word_in  (mem_rdata_i),
        .hit      (ptr_hit),
        .word_out (word_mod)
    );

    ea_level_limit #(.MAX_LEVELS(MAX_LEVELS), .LIMIT_EN(LIMIT_EN)) u_lim (
        .lvl      (lvl_q),
        .at_limit (lim_hit)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        lvl_d       = lvl_q;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_addr_o  = r_q.ptr;
        mem_wdata_o = word_mod;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (ind_i) begin
                        r_d.st  = ST_READ;
                        r_d.ptr = base_addr;
                        lvl_d   = '0;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.ea   = base_addr;
                    end
                end
            end
            ST_READ: begin
                mem_rd_o = 1'b1;
                r_d.st   = ST_EVAL;
            end
            ST_EVAL: begin
                mem_wr_o = ptr_hit;
                lvl_d    = lvl_q + LW'(1);
                if (!word_mod[DW-1]) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.ea   = word_mod[AW-1:0];
                end else if (lim_hit) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.ea   = word_mod[AW-1:0];
                end else begin
                    r_d.st  = ST_READ;
                    r_d.ptr = word_mod[AW-1:0];
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q   <= '{st: ST_IDLE, ptr: '0, ea: '0, done: 1'b0, err: 1'b0};
            lvl_q <= '0;
        end else begin
            r_q   <= r_d;
            lvl_q <= lvl_d;
        end
    end

    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;
    assign ea_o   = r_q.ea;
    assign err_o  = r_q.err;
endmodule

// File: rtl/ea_chain_gen_chk.sv
module ea_chain_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        ind_i,
    input logic [1:0]  mode_i,
    input logic [7:0]  disp_i,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [14:0] mem_addr_o,
    input logic [15:0] mem_wdata_o,
    input logic [15:0] mem_rdata_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [14:0] ea_o,
    input logic        err_o
);
    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R8
    wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_addr_o >= 15'd16 && mem_addr_o < 15'd32));

    // R6
    inc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_addr_o[3]) |-> mem_wdata_o == mem_rdata_i + 16'd1);

    // R7
    dec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_addr_o[3]) |-> mem_wdata_o == mem_rdata_i - 16'd1);

    // R1
    page0_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_o && !ind_i && mode_i == 2'b00)
        |=> (done_o && ea_o == {7'd0, $past(disp_i)}));

    // R5
    read_then_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> (busy_o && !mem_rd_o && !done_o));

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R4
    direct_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_o && !ind_i) |=> (!busy_o && !mem_rd_o && !mem_wr_o));
endmodule

bind ea_chain_gen ea_chain_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ind_i       (ind_i),
    .mode_i      (mode_i),
    .disp_i      (disp_i),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ea_o        (ea_o),
    .err_o       (err_o)
);

// File: tb/ea_chain_gen_test.sv
`timescale 1ns/1ps
module ea_chain_gen_test;
    localparam int MAXL  = 8;
    localparam int MSIZE = 1024;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        start = 1'b0, ind_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [7:0]  disp_i = 8'h00;
    logic [14:0] pc_i = '0;
    logic [15:0] acc_a_i = '0, acc_b_i = '0;
    logic        mem_rd_o, mem_wr_o;
    logic [14:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;
    logic        busy_o, done_o, err_o;
    logic [14:0] ea_o;

    ea_chain_gen #(.MAX_LEVELS(MAXL), .LIMIT_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ind_i(ind_i),
        .mode_i(mode_i), .disp_i(disp_i), .pc_i(pc_i),
        .acc_a_i(acc_a_i), .acc_b_i(acc_b_i),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .ea_o(ea_o), .err_o(err_o)
    );

    logic [15:0] mem [MSIZE];
    logic [15:0] sh  [MSIZE];
    int rd_cnt = 0;

    always @(posedge clk) begin
        if (mem_wr_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
        if (mem_rd_o) begin
            mem_rdata_i <= mem[mem_addr_o[9:0]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    function automatic logic [14:0] exp_base(input logic [1:0] m, input logic [7:0] d);
        logic [14:0] sx;
        sx = {{7{d[7]}}, d};
        case (m)
            2'b00:   return {7'd0, d};
            2'b01:   return pc_i + sx;
            2'b10:   return acc_a_i[14:0] + sx;
            default: return acc_b_i[14:0] + sx;
        endcase
    endfunction

    // reference walk over the shadow memory
    task automatic ref_walk(input logic [14:0] b, output logic [14:0] ea,
                            output int lv, output bit er);
        logic [14:0] p;
        logic [15:0] w;
        p = b; lv = 0; er = 1'b0; ea = '0;
        for (int k = 0; k < MAXL; k++) begin
            w = sh[p[9:0]];
            lv++;
            if (p >= 15'd16 && p < 15'd24) begin w = w + 16'd1; sh[p[9:0]] = w; end
            else if (p >= 15'd24 && p < 15'd32) begin w = w - 16'd1; sh[p[9:0]] = w; end
            if (!w[15]) begin ea = w[14:0]; return; end
            p = w[14:0];
        end
        er = 1'b1;
        ea = p;
    endtask

    task automatic run(input bit ind, input logic [1:0] m, input logic [7:0] d,
                       input bit poke, output int cyc);
        @(negedge clk);
        ind_i = ind; mode_i = m; disp_i = d; start = 1'b1;
        cyc = 0;
        for (int k = 0; k < 100; k++) begin
            @(posedge clk); #1;
            cyc++;
            if (k == 0) start = 1'b0;
            if (poke && k == 1) begin
                start = 1'b1; ind_i = 1'b0; mode_i = 2'b00; disp_i = 8'h11;
            end else if (poke && k == 2) begin
                start = 1'b0;
            end
            if (done_o) break;
        end
    endtask

    task automatic ind_case(input logic [1:0] m, input logic [7:0] d,
                            input string tag, input bit poke);
        logic [14:0] e_ea;
        int e_lv, cyc, diff;
        bit e_er;
        logic [14:0] a_ea;
        bit a_er;
        for (int i = 0; i < MSIZE; i++) sh[i] = mem[i];
        ref_walk(exp_base(m, d), e_ea, e_lv, e_er);
        run(1'b1, m, d, poke, cyc);
        a_ea = ea_o; a_er = err_o;
        chk(done_o == 1'b1, {tag, " done"}, done_o, 1);
        chk(cyc == 2 * e_lv + 1, {tag, " cycles"}, cyc, 2 * e_lv + 1);
        chk(a_er == e_er, {tag, " err"}, a_er, e_er);
        if (!e_er) chk(a_ea == e_ea, {tag, " ea"}, a_ea, e_ea);
        @(posedge clk); #1;
        diff = 0;
        for (int i = 0; i < MSIZE; i++) if (mem[i] !== sh[i]) diff++;
        chk(diff == 0, {tag, " memory"}, diff, 0);
        if (poke) chk(!done_o && !busy_o, "R10 no extra request", {done_o, busy_o}, 0);
    endtask

    initial begin
        int cyc, r0;
        logic [14:0] e;
        for (int i = 0; i < MSIZE; i++) mem[i] = 16'((i * 3) & 16'h7fff);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11
        chk({done_o, err_o, busy_o, mem_rd_o, mem_wr_o} == 5'b0, "R11 reset outputs",
            {done_o, err_o, busy_o, mem_rd_o, mem_wr_o}, 0);
        rst_n = 1'b1;

        // direct sweep, two register settings, all modes and displacements
        for (int s = 0; s < 2; s++) begin
            pc_i    = (s == 0) ? 15'h0000 : 15'h7ff0;
            acc_a_i = (s == 0) ? 16'h7fff : 16'h0040;
            acc_b_i = (s == 0) ? 16'h8005 : 16'hfffe;
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 256; d++) begin
                    r0 = rd_cnt;
                    run(1'b0, 2'(m), 8'(d), 1'b0, cyc);
                    e = exp_base(2'(m), 8'(d));
                    chk(ea_o == e, m == 0 ? "R1 page zero" : (m == 1 ? "R2 pc relative" : "R3 index"),
                        ea_o, e);
                    chk(cyc == 1 && rd_cnt == r0, "R4 direct timing", cyc, 1);
                end
            end
        end

        pc_i = 15'h0000; acc_a_i = 16'd200; acc_b_i = 16'h8000;
        // single level and multi-level chains
        mem[100] = 16'h0123;
        ind_case(2'b00, 8'd100, "R5 single", 1'b0);
        mem[200] = 16'h8000 | 16'd300; mem[300] = 16'h8000 | 16'd400; mem[400] = 16'h0055;
        ind_case(2'b10, 8'd0, "R5 three levels", 1'b0);
        // auto increment
        mem[16] = 16'h0100;
        ind_case(2'b00, 8'd16, "R6 inc ends", 1'b0);
        mem[23] = 16'h7fff; mem[0] = 16'h0042;
        ind_case(2'b00, 8'd23, "R6 inc sets bit15", 1'b0);
        mem[17] = 16'h8040; mem[65] = 16'h0005;
        ind_case(2'b00, 8'd17, "R6 inc continues", 1'b0);
        // auto decrement
        mem[24] = 16'h0200;
        ind_case(2'b00, 8'd24, "R7 dec ends", 1'b0);
        mem[31] = 16'h0000; mem[1023] = 16'h0077;
        ind_case(2'b00, 8'd31, "R7 dec wraps", 1'b0);
        mem[20] = 16'h8015; mem[22] = 16'h8019; mem[26] = 16'h0010;
        ind_case(2'b00, 8'd20, "R7 R6 window chain", 1'b0);
        // boundaries just outside the windows
        mem[15] = 16'h8000 | 16'd32; mem[32] = 16'h0444;
        ind_case(2'b00, 8'd15, "R8 outside windows", 1'b0);
        // level limit
        mem[100] = 16'h8000 | 16'd100;
        ind_case(2'b00, 8'd100, "R9 cyclic", 1'b0);
        for (int i = 0; i < 7; i++) mem[500 + i] = 16'h8000 | 16'(501 + i);
        mem[507] = 16'h0321;
        acc_a_i = 16'd500;
        ind_case(2'b10, 8'd0, "R9 exactly limit", 1'b0);
        mem[507] = 16'h8000 | 16'd508; mem[508] = 16'h0001;
        ind_case(2'b10, 8'd0, "R9 one over", 1'b0);
        // start while busy
        acc_a_i = 16'd200;
        ind_case(2'b10, 8'd0, "R10 busy start", 1'b1);
        finish_up();
    end
endmodule